// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit turns four asynchronous external interrupt pins into clean request lines for an interrupt controller. Each pin passes through a two-flop synchronizer. A per-line 2-bit sense code then picks what counts as a request: a high level, a low level, a rising transition or a falling transition. Line 0 drives the critical request group. Lines 1 to 3 drive the main request group. Ordering the requests within and across those groups is handled outside this unit.

One control word configures all four lines at once. For each line it holds a sense code, an enable (unmask) bit and a write-one acknowledge bit. In the edge modes a sticky capture flag per line keeps an event until software acknowledges it. In the level modes the request follows the synchronized pin. Software can read back the sense codes, the enables and the capture flags at all times. A write replaces every sense code and enable bit, so software keeps its own copy and sets the acknowledge bits only for the lines it is clearing.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset, all sense codes, enable bits and capture flags are 0, and `crit_req_o` and `main_req_o` are low.
- R2: A write with `cfg_we` high loads the sense code of line i from `cfg_wdata[2i+1:2i]` and its enable bit from `cfg_wdata[8+i]`. `status_o` reads back as {capture flags[3:0], enables[3:0], sense codes[7:0]}, with the sense code of line i at bits 2i+1:2i.
- R3: A pin change reaches an enabled level-mode request on the third rising clock edge after the change, and not earlier. This delay comes from two synchronizer flops followed by the output register.
- R4: Sense code 0 (active high): an enabled line requests while its synchronized pin is 1.
- R5: Sense code 3 (active low): an enabled line requests while its synchronized pin is 0.
- R6: Sense code 1 (rising edge): a synchronized 0 to 1 transition sets the capture flag, and the request rises on the same edge the flag sets. The flag stays set when the pin falls again.
- R7: Sense code 2 (falling edge): a synchronized 1 to 0 transition sets the capture flag and the request. A rising transition has no effect.
- R8: Writing 1 to `cfg_wdata[12+i]` clears the capture flag of line i, and its edge-mode request drops on the same edge. If a new selected edge arrives on the edge that carries the clear, the flag stays set.
- R9: A disabled line drives no request, but its capture flag still records edges. After the line is enabled, a pending flag raises the request one edge after the enabling write.
- R10: A write that changes a line's sense code clears that line's capture flag, so no request results from the change.
- R11: Line 0 drives `crit_req_o`. Lines 1, 2 and 3 drive `main_req_o[0]`, `[1]` and `[2]`.
- R12: In rising-edge mode a falling transition leaves the capture flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: sense codes [7:0], enables [11:8], acknowledge bits [15:12] |
| status_o | output | 16 | Read back: capture flags [15:12], enables [11:8], sense codes [7:0] |
| crit_req_o | output | 1 | Registered request from line 0 to the critical group |
| main_req_o | output | 3 | Registered requests from lines 1 to 3 to the main group |

## Verification
The assertions assume that the control word changes only through `cfg_we`. They also assume that `pin_i` is seen only through the synchronizer, so the detection logic never observes a value that changes between edges. The bench drives pins and writes on the falling clock edge and holds each pin level for several cycles, which makes every transition visible to both synchronizer stages. It keeps a shadow copy of the sense codes and enables, so an acknowledge write changes a sense code only when a test means to change it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  localparam int SENSE_W = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  sense_e sense,
  input  logic   en,
  input  logic   sense_chg,
  input  logic   clr,
  output logic   flag_o,
  output logic   req_o
);
  logic prev_q, flag_q, flag_d, req_q, hit, act;

  // Edge detection works on synchronized samples only
  always_comb begin
    hit = 1'b0;
    case (sense)
      SENSE_RISE: hit = pin_s & ~prev_q;
      SENSE_FALL: hit = ~pin_s & prev_q;
      default:    hit = 1'b0;
    endcase
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;        // a new edge outranks an acknowledge
    if (sense_chg) flag_d = 1'b0;  // a mode change never leaves a stale event
  end

  always_comb begin
    case (sense)
      SENSE_LVL_HI: act = pin_s;
      SENSE_LVL_LO: act = ~pin_s;
      default:      act = flag_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
      req_q  <= en & act;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = req_q;

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req_q);
  p_level_high_r4: assert property (@(posedge clk) disable iff (rst)
    (en && sense == SENSE_LVL_HI) |=> (req_q == $past(pin_s)));
  p_level_low_r5: assert property (@(posedge clk) disable iff (rst)
    (en && sense == SENSE_LVL_LO) |=> (req_q == !$past(pin_s)));
  p_mode_change_clears_r10: assert property (@(posedge clk) disable iff (rst)
    sense_chg |=> !flag_q);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr && !sense_chg) |=> flag_q);
  p_edge_req_tracks_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (sense == SENSE_RISE || sense == SENSE_FALL)) |=> (req_q == flag_q));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   pin_i,
  input  logic                   cfg_we,
  input  logic [4*NUM_LINES-1:0] cfg_wdata,
  output logic [4*NUM_LINES-1:0] status_o,
  output logic                   crit_req_o,
  output logic [NUM_LINES-2:0]   main_req_o
);
  localparam int SENSE_BITS = SENSE_W * NUM_LINES;
  localparam int EN_LSB     = SENSE_BITS;
  localparam int CLR_LSB    = SENSE_BITS + NUM_LINES;

  logic [SENSE_BITS-1:0] sense_q;
  logic [NUM_LINES-1:0]  en_q, pin_s, flags, reqs, chg, clr;

  ext_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      en_q    <= '0;
    end else if (cfg_we) begin
      sense_q <= cfg_wdata[SENSE_BITS-1:0];
      en_q    <= cfg_wdata[EN_LSB +: NUM_LINES];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign chg[i] = cfg_we &&
      (cfg_wdata[SENSE_W*i +: SENSE_W] != sense_q[SENSE_W*i +: SENSE_W]);
    assign clr[i] = cfg_we && cfg_wdata[CLR_LSB + i];

    ext_irq_line i_line (
      .clk(clk), .rst(rst), .pin_s(pin_s[i]),
      .sense(sense_e'(sense_q[SENSE_W*i +: SENSE_W])),
      .en(en_q[i]), .sense_chg(chg[i]), .clr(clr[i]),
      .flag_o(flags[i]), .req_o(reqs[i])
    );
  end

  assign status_o   = {flags, en_q, sense_q};
  assign crit_req_o = reqs[0];
  assign main_req_o = reqs[NUM_LINES-1:1];

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !crit_req_o && main_req_o == '0));
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (status_o[CLR_LSB-1:0] == $past(cfg_wdata[CLR_LSB-1:0])));
endmodule

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] status;
  logic        crit;
  logic [2:0]  main_r;

  int checks = 0, fails = 0;
  logic [3:0] en_sh = '0;
  logic [7:0] sense_sh = '0;

  always #5 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst(rst), .pin_i(pin), .cfg_we(we), .cfg_wdata(wdata),
    .status_o(status), .crit_req_o(crit), .main_req_o(main_r)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] clrb);
    wdata = {clrb, en_sh, sense_sh};
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status", status, 0);
    check("R1 crit", crit, 0);
    check("R1 main", main_r, 0);
  endtask

  task automatic t_readback;
    en_sh = 4'b1010; sense_sh = 8'hE4;
    write_cfg(4'b0000);
    check("R2 readback", status, 16'h0AE4);
    en_sh = '0; sense_sh = '0;
    write_cfg(4'b0000);
    check("R2 cleared", status, 16'h0000);
  endtask

  task automatic t_latency_high;
    en_sh = 4'hF; sense_sh = 8'h00;
    write_cfg(4'b0000);
    pin[1] = 1'b1;
    step(2);
    check("R3 not before third edge", main_r, 3'b000);
    step(1);
    check("R3 R4 R11 line1 on main0", main_r, 3'b001);
    check("R11 crit idle", crit, 0);
    pin[1] = 1'b0;
    step(3);
    check("R4 level drops", main_r, 3'b000);
    pin[0] = 1'b1;
    step(3);
    check("R11 line0 on crit", crit, 1);
    check("R11 main idle", main_r, 3'b000);
    pin[0] = 1'b0;
    step(3);
    check("R4 crit drops", crit, 0);
  endtask

  task automatic t_level_low;
    sense_sh = 8'h30;
    write_cfg(4'b0000);
    step(1);
    check("R5 low pin requests", main_r[1], 1);
    pin[2] = 1'b1;
    step(3);
    check("R5 high pin quiet", main_r[1], 0);
    pin[2] = 1'b0;
    step(3);
    check("R5 low again", main_r[1], 1);
    sense_sh = 8'h00;
    write_cfg(4'b0000);
    step(1);
  endtask

  task automatic t_rise;
    sense_sh = 8'h40;
    write_cfg(4'b0000);
    pin[3] = 1'b1;
    step(3);
    check("R6 rise captured", main_r[2], 1);
    pin[3] = 1'b0;
    step(5);
    check("R6 sticky after fall", main_r[2], 1);
    check("R6 flag read", status[15], 1);
    write_cfg(4'b1000);
    check("R8 clear drops req", main_r[2], 0);
    check("R8 clear drops flag", status[15], 0);
    pin[3] = 1'b1;
    step(4);
    write_cfg(4'b1000);
    pin[3] = 1'b0;
    step(4);
    check("R12 fall ignored in rise mode", status[15], 0);
    check("R12 no request", main_r[2], 0);
  endtask

  task automatic t_fall;
    sense_sh = 8'h08;
    write_cfg(4'b0000);
    pin[1] = 1'b1;
    step(4);
    check("R7 rise ignored", main_r[0], 0);
    pin[1] = 1'b0;
    step(3);
    check("R7 fall captured", main_r[0], 1);
    pin[1] = 1'b1;
    step(3);
    pin[1] = 1'b0;
    step(2);
    write_cfg(4'b0010);
    check("R8 edge beats clear flag", status[13], 1);
    check("R8 edge beats clear req", main_r[0], 1);
    write_cfg(4'b0010);
    check("R8 plain clear", status[13], 0);
  endtask

  task automatic t_disable_and_mode;
    en_sh = 4'b1011; sense_sh = 8'h10;
    write_cfg(4'b0000);
    pin[2] = 1'b1;
    step(3);
    check("R9 disabled no req", main_r[1], 0);
    check("R9 flag still records", status[14], 1);
    en_sh = 4'hF;
    write_cfg(4'b0000);
    check("R9 not on enable edge", main_r[1], 0);
    step(1);
    check("R9 pending flag raises req", main_r[1], 1);
    sense_sh = 8'h20;
    write_cfg(4'b0000);
    check("R10 mode change clears flag", status[14], 0);
    step(2);
    check("R10 no false request", main_r[1], 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_readback();
    t_latency_high();
    t_level_low();
    t_rise();
    t_fall();
    t_disable_and_mode();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule